// File: doc/BRIEF.md
# Interrupt Recognition Timing Sequencer

This block decides, cycle by cycle, when a small 8-bit processor core leaves its instruction stream to enter its interrupt sequence. The request line is level-sensitive. It passes through a short sampling pipeline. At the final cycle of each instruction, the core checks the oldest stage of that pipeline. A request therefore has to be present some cycles before an instruction ends for it to be honoured at that boundary. If it comes later, one more whole instruction runs first. Once an interrupt is accepted, the block steps through a fixed seven-cycle entry sequence. During that sequence it reports which entry cycle the core is in.

The core strobes `instr_last` during the final cycle of every instruction. It raises `bus_stall` while an external master holds the bus. Stalled cycles do not advance the instruction or the entry sequence. The first sampling stage still latches during a stall, so a request that arrives while the bus is held is recognised one cycle sooner. The block also measures the delay from a request to its acceptance, counting stalled cycles too, so that latency jitter can be observed directly.

Top module: `irq_recog_seq`

## Requirements
- R1: After reset, `take_irq`, `entry_busy`, `entry_idx` and `req_latency` are all zero, and no request is pending.
- R2: When `irq_req` is high in a cycle at least two advancing (non-stalled) cycles before an instruction's final cycle, and stays high, `take_irq` is 1 in that final cycle. For example, a request in cycle 4 of a 6-cycle instruction is taken in cycle 6.
- R3: When a request first appears in the last or second-to-last advancing cycle of an instruction, it is not taken at that boundary. It is taken at the end of the following instruction. For example, a request in cycle 1 of a 2-cycle instruction, or in cycle 5 of a 6-cycle instruction, is deferred.
- R4: While `irq_disable` is 1, `take_irq` stays 0 at every boundary. A request that is still held is taken at the first boundary after the flag returns to 0.
- R5: In the cycle after `take_irq`, `entry_busy` is 1 and `entry_idx` is 1. Each advancing cycle increments the index. After index 7, the next advancing cycle returns `entry_busy` and `entry_idx` to 0. `entry_idx` is 0 whenever the sequence is idle. `instr_last` is ignored while busy.
- R6: A stalled cycle holds `entry_idx` and never produces `take_irq`, even when `instr_last` is high in that cycle.
- R7: The first sampling stage latches `irq_req` in stalled cycles as well as advancing ones. A request that rises during a stall is therefore taken at the end of a 3-cycle instruction when the stall fell between that instruction's cycles 1 and 2. The same request arriving in cycle 2 with no stall is not taken there.
- R8: On acceptance, `req_latency` becomes the number of cycles, stalled ones included, from the first cycle of the current high request (counted as 0) to the accepting cycle. It holds that value until the next acceptance. Measurement restarts when the request drops or after an entry sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Level-sensitive interrupt request |
| irq_disable | input | 1 | Interrupt-disable flag of the core |
| instr_last | input | 1 | High in the final cycle of the current instruction |
| bus_stall | input | 1 | High while the bus is held and the core does not advance |
| take_irq | output | 1 | Interrupt accepted at this instruction boundary |
| entry_busy | output | 1 | Entry sequence in progress |
| entry_idx | output | 3 | Entry cycle number 1..7, 0 when idle |
| req_latency | output | 8 | Cycles from request to acceptance, last measured |

## Verification
The main function is driven with requests that rise at different positions inside 2-cycle and 6-cycle instructions. Some rise early enough to be accepted at the current boundary and some are deferred to the next one, and the measured latency (2 or 3) shows which case occurred. A request held while the disable flag is set shows that masking defers acceptance without losing the request. Pairs of otherwise identical sequences, one with a stall inserted and one without, show the absorbed sampling cycle. Stalls placed on an instruction's final cycle and inside the entry sequence show that nothing advances during a bus hold.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int ENTRY_LEN   = 7;
    localparam int SYNC_STAGES = 2;
    localparam int LAT_W       = 8;

    typedef struct packed {
        logic req;
        logic dis;
        logic last;
        logic stall;
    } cyc_in_t;

    function automatic logic boundary_ok(cyc_in_t ci, logic busy, logic seen);
        return ci.last && !ci.stall && !busy && !ci.dis && seen;
    endfunction

endpackage

// File: rtl/irq_req_sampler.sv
module irq_req_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic stall,
    output logic seen
);
    logic [STAGES-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg[0] <= req;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg <= '0;
                end else begin
                    stg[0] <= req;
                    if (!stall) begin
                        for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                    end
                end
            end
        end
    endgenerate

    assign seen = stg[STAGES-1];
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int LEN = 7,
    parameter int IW  = $clog2(LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stall,
    output logic          busy,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST_IDX = IW'(LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (start) begin
            idx <= IW'(1);
        end else if (idx != '0 && !stall) begin
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

    assign busy = (idx != '0);
endmodule

// File: rtl/irq_latency_meter.sv
module irq_latency_meter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic         busy,
    input  logic         take,
    output logic [W-1:0] latency
);
    logic         run;
    logic [W-1:0] cnt;
    logic [W-1:0] cur;

    assign cur = run ? cnt : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            cnt     <= '0;
            latency <= '0;
        end else begin
            if (take) latency <= cur;
            if (take || busy || !req) begin
                run <= 1'b0;
                cnt <= '0;
            end else if (!run) begin
                run <= 1'b1;
                cnt <= W'(1);
            end else if (cnt != '1) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_recog_seq.sv
module irq_recog_seq
    import irq_seq_pkg::*;
#(
    parameter int ENTRY_CYCLES = ENTRY_LEN,
    parameter int STAGES       = SYNC_STAGES,
    parameter int LW           = LAT_W,
    parameter int IW           = $clog2(ENTRY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_req,
    input  logic          irq_disable,
    input  logic          instr_last,
    input  logic          bus_stall,
    output logic          take_irq,
    output logic          entry_busy,
    output logic [IW-1:0] entry_idx,
    output logic [LW-1:0] req_latency
);
    cyc_in_t ci;
    logic    seen;

    assign ci = '{req: irq_req, dis: irq_disable, last: instr_last, stall: bus_stall};

    irq_req_sampler #(.STAGES(STAGES)) u_samp (
        .clk(clk), .rst(rst), .req(ci.req), .stall(ci.stall), .seen(seen)
    );

    assign take_irq = boundary_ok(ci, entry_busy, seen);

    irq_entry_seq #(.LEN(ENTRY_CYCLES), .IW(IW)) u_seq (
        .clk(clk), .rst(rst), .start(take_irq), .stall(ci.stall),
        .busy(entry_busy), .idx(entry_idx)
    );

    irq_latency_meter #(.W(LW)) u_lat (
        .clk(clk), .rst(rst), .req(ci.req), .busy(entry_busy),
        .take(take_irq), .latency(req_latency)
    );
endmodule

// File: rtl/irq_recog_chk.sv
module irq_recog_chk #(
    parameter int ENTRY_CYCLES = 7,
    parameter int IW           = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          irq_disable,
    input logic          bus_stall,
    input logic          take_irq,
    input logic          entry_busy,
    input logic [IW-1:0] entry_idx
);
    AST_ENTRY_START: assert property (@(posedge clk) disable iff (rst)
        take_irq |=> entry_busy && entry_idx == IW'(1)); // R5
    AST_ENTRY_END: assert property (@(posedge clk) disable iff (rst)
        entry_busy && !bus_stall && entry_idx == IW'(ENTRY_CYCLES) |=> !entry_busy); // R5
    AST_IDLE_IDX: assert property (@(posedge clk) disable iff (rst)
        !entry_busy |-> entry_idx == '0); // R5
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
        entry_busy |-> !take_irq); // R5
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        entry_busy && bus_stall |=> $stable(entry_idx)); // R6
    AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (rst)
        bus_stall |-> !take_irq); // R6
    AST_NO_TAKE_MASKED: assert property (@(posedge clk) disable iff (rst)
        irq_disable |-> !take_irq); // R4
endmodule

bind irq_recog_seq irq_recog_chk #(.ENTRY_CYCLES(ENTRY_CYCLES), .IW(IW)) u_chk (
    .clk(clk), .rst(rst), .irq_disable(irq_disable), .bus_stall(bus_stall),
    .take_irq(take_irq), .entry_busy(entry_busy), .entry_idx(entry_idx)
);

// File: tb/tb_irq_recog_seq.sv
module tb_irq_recog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst;
    logic       irq_req, irq_disable, instr_last, bus_stall;
    logic       take_irq, entry_busy;
    logic [2:0] entry_idx;
    logic [7:0] req_latency;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    bit m_s1, m_s2, m_run;
    int m_idx, m_cnt, m_lat;
    bit g_irq, g_dis, g_took;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_recog_seq dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_disable(irq_disable),
        .instr_last(instr_last), .bus_stall(bus_stall), .take_irq(take_irq),
        .entry_busy(entry_busy), .entry_idx(entry_idx), .req_latency(req_latency)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit irq, input bit dis, input bit last,
                        input bit stl, input string tag);
        bit e_take, busy_now, nxt_s2;
        int cur;
        irq_req = irq; irq_disable = dis; instr_last = last; bus_stall = stl;
        #1;
        cur = m_run ? m_cnt : 0;
        busy_now = (m_idx != 0);
        e_take = last && !stl && !busy_now && !dis && m_s2;
        chk(take_irq === e_take, tag, "take_irq", int'(take_irq), int'(e_take));
        chk(entry_busy === busy_now, tag, "entry_busy", int'(entry_busy), int'(busy_now));
        chk(int'(entry_idx) == m_idx, tag, "entry_idx", int'(entry_idx), m_idx);
        chk(int'(req_latency) == m_lat, tag, "req_latency", int'(req_latency), m_lat);
        if (take_irq === 1'b1) g_took = 1;
        @(posedge clk);
        nxt_s2 = stl ? m_s2 : m_s1;
        m_s1 = irq;
        m_s2 = nxt_s2;
        if (e_take) m_idx = 1;
        else if (busy_now && !stl) m_idx = (m_idx == 7) ? 0 : m_idx + 1;
        if (e_take) m_lat = cur;
        if (e_take || busy_now || !irq) begin
            m_run = 0; m_cnt = 0;
        end else if (!m_run) begin
            m_run = 1; m_cnt = 1;
        end else if (m_cnt < 255) begin
            m_cnt++;
        end
        @(negedge clk);
    endtask

    // instruction of len cycles, request raised (and held) at cycle 'at' (0 = unchanged)
    task automatic instr(input int len, input int at, input string tag);
        for (int i = 1; i <= len; i++) begin
            if (at != 0 && i == at) g_irq = 1;
            step(g_irq, g_dis, i == len, 0, tag);
        end
    endtask

    // run the entry sequence out: strobe last (ignored) and one stall inside it
    task automatic entry_done();
        int n = 0;
        g_irq = 0;
        while (m_idx != 0) begin
            if (n == 0)      step(0, g_dis, 1, 0, "R5");
            else if (n == 2) step(0, g_dis, 0, 1, "R6");
            else             step(0, g_dis, 0, 0, "R5");
            n++;
        end
    endtask

    task automatic flush();
        g_irq = 0;
        step(0, g_dis, 0, 0, "R1");
        step(0, g_dis, 0, 0, "R1");
    endtask

    initial begin
        irq_req = 0; irq_disable = 0; instr_last = 0; bus_stall = 0;
        g_irq = 0; g_dis = 0; g_took = 0;
        m_s1 = 0; m_s2 = 0; m_run = 0; m_idx = 0; m_cnt = 0; m_lat = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk(take_irq === 1'b0, "R1", "take_irq", int'(take_irq), 0);
        chk(entry_busy === 1'b0, "R1", "entry_busy", int'(entry_busy), 0);
        chk(entry_idx === 3'd0, "R1", "entry_idx", int'(entry_idx), 0);
        chk(req_latency === 8'd0, "R1", "req_latency", int'(req_latency), 0);
        @(negedge clk);
        instr(2, 0, "R1");

        // R2: request in cycle 4 of a 6-cycle instruction
        g_took = 0;
        instr(6, 4, "R2");
        chk(g_took == 1, "R2", "taken after rmw c4", int'(g_took), 1);
        chk(int'(req_latency) == 2, "R2", "latency", int'(req_latency), 2);
        entry_done();
        flush();

        // R3: request in cycle 1 of a 2-cycle instruction
        g_took = 0;
        instr(2, 1, "R3");
        chk(g_took == 0, "R3", "not taken after nop", int'(g_took), 0);
        instr(2, 0, "R3");
        chk(g_took == 1, "R3", "taken after next nop", int'(g_took), 1);
        chk(int'(req_latency) == 3, "R3", "latency", int'(req_latency), 3);
        entry_done();
        flush();

        // R3: request in cycle 5 of a 6-cycle instruction
        g_took = 0;
        instr(6, 5, "R3");
        chk(g_took == 0, "R3", "rmw c5 deferred", int'(g_took), 0);
        instr(2, 0, "R3");
        chk(g_took == 1, "R3", "taken after next", int'(g_took), 1);
        chk(int'(req_latency) == 3, "R3", "latency", int'(req_latency), 3);
        entry_done();
        flush();

        // R4 masked request held, then unmasked
        g_took = 0;
        g_dis = 1;
        instr(3, 1, "R4");
        instr(3, 0, "R4");
        chk(g_took == 0, "R4", "masked", int'(g_took), 0);
        g_dis = 0;
        instr(2, 0, "R4");
        chk(g_took == 1, "R4", "taken after unmask", int'(g_took), 1);
        chk(int'(req_latency) == 7, "R8", "latency incl masked span", int'(req_latency), 7);
        entry_done();
        chk(int'(req_latency) == 7, "R8", "latency held", int'(req_latency), 7);
        flush();

        // R7 request rises during a stall between cycles 1 and 2
        g_took = 0;
        step(0, 0, 0, 0, "R7");
        step(1, 0, 0, 1, "R7");
        step(1, 0, 0, 0, "R7");
        step(1, 0, 1, 0, "R7");
        chk(g_took == 1, "R7", "stall absorbs first sample", int'(g_took), 1);
        chk(int'(req_latency) == 2, "R7", "latency", int'(req_latency), 2);
        entry_done();
        flush();

        // R7 contrast: same request in cycle 2 without stall
        g_took = 0;
        step(0, 0, 0, 0, "R7");
        step(1, 0, 0, 0, "R7");
        step(1, 0, 1, 0, "R7");
        chk(g_took == 0, "R7", "no stall, deferred", int'(g_took), 0);
        g_irq = 1;
        instr(2, 0, "R8");
        chk(g_took == 1, "R7", "taken after next", int'(g_took), 1);
        chk(int'(req_latency) == 3, "R8", "latency", int'(req_latency), 3);
        entry_done();
        flush();

        // R6 stalled final-cycle strobe is not a boundary
        g_took = 0;
        step(1, 0, 0, 0, "R6");
        step(1, 0, 0, 0, "R6");
        step(1, 0, 1, 1, "R6");
        chk(g_took == 0, "R6", "stalled last ignored", int'(g_took), 0);
        step(1, 0, 1, 0, "R6");
        chk(g_took == 1, "R6", "taken on advancing last", int'(g_took), 1);
        chk(int'(req_latency) == 3, "R8", "latency with stall", int'(req_latency), 3);
        entry_done();
        flush();

        done = 1;
        summary();
    end
endmodule